// File: doc/BRIEF.md
# Real-Mode Interrupt Entry Sequencer

This block sits beside the fetch unit of a 16-bit real-mode core. It accepts a raised interrupt with its vector number, holds it pending, and at the next instruction boundary it runs the vector entry before the core is allowed to fetch another opcode. The entry saves the machine context on the stack and redirects execution through a table of 4-byte entries at physical address zero.

The sequence has six steps. It pushes the flags word and then clears the interrupt-enable and trap flags. It pushes the old code segment and then loads the new one from the table. It pushes the old instruction pointer and then loads the new one. Memory traffic goes through one word-wide port with a request/ready handshake. The core's registers are updated through write-enable strobes. A sticky halt input stops all further fetching and all further entries.

The core holds `boundary_i` high while it waits to fetch. It fetches only while `fetch_ok_o` is high.

Top module: `rm_intr_entry`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `halted_o`, `mem_req_o` and all register write strobes are low. With nothing pending, `fetch_ok_o` follows `boundary_i`.
- R2: The new code segment is read from word address vector*4+2 and the new instruction pointer from vector*4. Both are reads (`mem_we_o`=0). The read data is returned on `cs_o`/`ip_o` with `cs_we_o`/`ip_we_o` in the cycle the read is accepted.
- R3: The entry runs in this order: write flags; flags strobe with bit 9 (interrupt enable) and bit 8 (trap) cleared and all other bits kept; write old CS; read new CS; write old IP; read new IP.
- R4: Each push first lowers SP by 2 and then writes at ((SS<<4)+SP) mod 2^20. SP wraps modulo 2^16. `sp_o` with `sp_we_o` gives the lowered SP at each push, so the final SP is the original minus 6.
- R5: A pending interrupt is taken only while `boundary_i` is high. In that case `fetch_ok_o` stays low, and the first request appears in the cycle after the boundary is seen.
- R6: A pending vector other than 0 and 2 is not taken while flags bit 9 is clear. It stays pending, `fetch_ok_o` stays usable, and the entry runs once the bit is set.
- R7: Vectors 0 and 2 are taken whatever the state of flags bit 9.
- R8: Once `halt_i` has been seen, `halted_o` stays high until reset, `fetch_ok_o` stays low and no new entry starts. An entry already running completes.
- R9: `busy_o` is high for the whole entry. `done_o` pulses for exactly one cycle after the IP load. The pending interrupt is then cleared, so it is not taken a second time.
- R10: Only one memory request is outstanding at a time. While `mem_ready_i` is low, the request, address, direction and write data are held unchanged, for any number of wait cycles.
- R11: A raise that arrives while an entry is running is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Raise an interrupt (one-cycle strobe) |
| raise_vec_i | input | 8 | Vector number for the raise |
| halt_i | input | 1 | Enter the halted state (sticky) |
| boundary_i | input | 1 | Core is at an instruction boundary and wants to fetch |
| fetch_ok_o | output | 1 | Core may fetch the next opcode |
| busy_o | output | 1 | Entry sequence running |
| done_o | output | 1 | New CS:IP valid, one-cycle pulse |
| halted_o | output | 1 | Halted state |
| cs_i | input | 16 | Current code segment |
| ip_i | input | 16 | Current instruction pointer |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Stack pointer |
| flags_i | input | 16 | Flags word |
| cs_we_o | output | 1 | Load strobe for CS |
| cs_o | output | 16 | New CS value |
| ip_we_o | output | 1 | Load strobe for IP |
| ip_o | output | 16 | New IP value |
| sp_we_o | output | 1 | Load strobe for SP |
| sp_o | output | 16 | New SP value |
| flags_we_o | output | 1 | Load strobe for flags |
| flags_o | output | 16 | Flags with IF and TF cleared |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rdata_i | input | 16 | Read data, valid with ready |

## Verification
The assertions assume three things about the inputs:
- `mem_ready_i` is only high while a request is outstanding.
- The core does not change CS, IP, SS, SP or flags behind the sequencer's back while `busy_o` is high.
- `raise_i` is a strobe.

The bench respects all three. Its memory model raises ready only against a live request, after a programmed wait of 0 to 3 cycles. Its core model changes its registers only through the sequencer's strobes. It drives every input at the falling edge, with raises one cycle wide.

// File: rtl/rm_intr_pkg.sv
package rm_intr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_FL,
    ST_PUSH_CS,
    ST_LOAD_CS,
    ST_PUSH_IP,
    ST_LOAD_IP,
    ST_DONE
  } ent_state_e;

  localparam int unsigned DEF_IF_BIT = 9;
  localparam int unsigned DEF_TF_BIT = 8;
  localparam int unsigned PUSH_BYTES = 2;
endpackage

// File: rtl/rm_pend_latch.sv
module rm_pend_latch #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned NMI_A = 0,
  parameter int unsigned NMI_B = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [VEC_W-1:0] raise_vec_i,
  input  logic             halt_i,
  input  logic             busy_i,
  input  logic             clear_i,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             nmi_o,
  output logic             halted_o
);
  logic             pend_q;
  logic [VEC_W-1:0] vec_q;
  logic             halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      vec_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (halt_i) halted_q <= 1'b1;
      if (clear_i) begin
        pend_q <= 1'b0;
      end else if (raise_i && !busy_i) begin
        pend_q <= 1'b1;
        vec_q  <= raise_vec_i;
      end
    end
  end

  assign pend_o   = pend_q;
  assign vec_o    = vec_q;
  assign nmi_o    = (vec_q == VEC_W'(NMI_A)) || (vec_q == VEC_W'(NMI_B));
  assign halted_o = halted_q;

  assert_pend_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !pend_o);
  assert_busy_raise_dropped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !clear_i && pend_o) |=> $stable(vec_o));
  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [ADDR_W-1:0] vec_ip_addr_o,
  output logic [ADDR_W-1:0] vec_cs_addr_o
);
  localparam int unsigned SEG_W = WORD_W + SEG_SHIFT;
  localparam int unsigned SUM_W = ((SEG_W > ADDR_W) ? SEG_W : ADDR_W) + 1;
  localparam int unsigned ENT_SHIFT = 2;

  logic [SUM_W-1:0] seg_base;
  logic [SUM_W-1:0] stk_sum;
  logic [SUM_W-1:0] ent_base;

  always_comb begin
    seg_base = SUM_W'(ss_i) << SEG_SHIFT;
    stk_sum  = seg_base + SUM_W'(sp_i);
    ent_base = SUM_W'(vec_i) << ENT_SHIFT;
  end

  assign stk_addr_o    = stk_sum[ADDR_W-1:0];
  assign vec_ip_addr_o = ent_base[ADDR_W-1:0];
  assign vec_cs_addr_o = ent_base[ADDR_W-1:0] + ADDR_W'(2);
endmodule

// File: rtl/rm_entry_fsm.sv
module rm_entry_fsm
  import rm_intr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned IF_BIT = DEF_IF_BIT,
  parameter int unsigned TF_BIT = DEF_TF_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [ADDR_W-1:0] stk_addr_i,
  input  logic [ADDR_W-1:0] vec_cs_addr_i,
  input  logic [ADDR_W-1:0] vec_ip_addr_i,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] ss_cur_o,
  output logic [WORD_W-1:0] sp_dec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              sp_we_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              flags_we_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              cs_we_o,
  output logic [WORD_W-1:0] cs_o,
  output logic              ip_we_o,
  output logic [WORD_W-1:0] ip_o
);
  localparam logic [WORD_W-1:0] CLR_MASK =
    ~((WORD_W'(1) << IF_BIT) | (WORD_W'(1) << TF_BIT));

  ent_state_e        state_q, state_d;
  logic [WORD_W-1:0] cs_q, ip_q, ss_q, sp_q, flags_q;
  logic              is_push, is_load, step;

  always_comb begin
    is_push = (state_q == ST_PUSH_FL) || (state_q == ST_PUSH_CS) || (state_q == ST_PUSH_IP);
    is_load = (state_q == ST_LOAD_CS) || (state_q == ST_LOAD_IP);
    step    = (is_push || is_load) && mem_ready_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PUSH_FL;
      ST_PUSH_FL: if (step) state_d = ST_PUSH_CS;
      ST_PUSH_CS: if (step) state_d = ST_LOAD_CS;
      ST_LOAD_CS: if (step) state_d = ST_PUSH_IP;
      ST_PUSH_IP: if (step) state_d = ST_LOAD_IP;
      ST_LOAD_IP: if (step) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      flags_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        cs_q    <= cs_i;
        ip_q    <= ip_i;
        ss_q    <= ss_i;
        sp_q    <= sp_i;
        flags_q <= flags_i;
      end else if (is_push && mem_ready_i) begin
        sp_q <= sp_dec_o;
      end
    end
  end

  assign sp_dec_o = sp_q - WORD_W'(PUSH_BYTES);
  assign ss_cur_o = ss_q;

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_FL: begin mem_addr_o = stk_addr_i;    mem_wdata_o = flags_q; end
      ST_PUSH_CS: begin mem_addr_o = stk_addr_i;    mem_wdata_o = cs_q;    end
      ST_PUSH_IP: begin mem_addr_o = stk_addr_i;    mem_wdata_o = ip_q;    end
      ST_LOAD_CS: mem_addr_o = vec_cs_addr_i;
      ST_LOAD_IP: mem_addr_o = vec_ip_addr_i;
      default: ;
    endcase
  end

  assign mem_req_o  = is_push || is_load;
  assign mem_we_o   = is_push;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign sp_we_o    = is_push && mem_ready_i;
  assign sp_o       = sp_dec_o;
  assign flags_we_o = (state_q == ST_PUSH_FL) && mem_ready_i;
  assign flags_o    = flags_q & CLR_MASK;
  assign cs_we_o    = (state_q == ST_LOAD_CS) && mem_ready_i;
  assign cs_o       = mem_rdata_i;
  assign ip_we_o    = (state_q == ST_LOAD_IP) && mem_ready_i;
  assign ip_o       = mem_rdata_i;

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_cs_from_table_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |-> (!mem_we_o && mem_addr_o[1:0] == 2'b10));
  assert_ip_from_table_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ip_we_o |-> (!mem_we_o && mem_addr_o[1:0] == 2'b00));
  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_ip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ip_we_o));
  assert_flags_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_o |-> (sp_we_o && mem_we_o));
endmodule

// File: rtl/rm_intr_entry.sv
module rm_intr_entry
  import rm_intr_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned IF_BIT    = DEF_IF_BIT,
  parameter int unsigned TF_BIT    = DEF_TF_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic [VEC_W-1:0]  raise_vec_i,
  input  logic              halt_i,
  input  logic              boundary_i,
  output logic              fetch_ok_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              halted_o,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] flags_i,
  output logic              cs_we_o,
  output logic [WORD_W-1:0] cs_o,
  output logic              ip_we_o,
  output logic [WORD_W-1:0] ip_o,
  output logic              sp_we_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              flags_we_o,
  output logic [WORD_W-1:0] flags_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic              pend, nmi, halted_q, halted_any, can_take, start;
  logic [VEC_W-1:0]  vec;
  logic [WORD_W-1:0] ss_cur, sp_dec;
  logic [ADDR_W-1:0] stk_addr, vec_ip_addr, vec_cs_addr;

  rm_pend_latch #(.VEC_W(VEC_W)) i_pend (
    .clk_i, .rst_ni, .raise_i, .raise_vec_i, .halt_i,
    .busy_i(busy_o), .clear_i(done_o),
    .pend_o(pend), .vec_o(vec), .nmi_o(nmi), .halted_o(halted_q)
  );

  rm_addr_gen #(.VEC_W(VEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) i_addr (
    .ss_i(ss_cur), .sp_i(sp_dec), .vec_i(vec),
    .stk_addr_o(stk_addr), .vec_ip_addr_o(vec_ip_addr), .vec_cs_addr_o(vec_cs_addr)
  );

  // halt seen this cycle already blocks both fetch and entry
  assign halted_any = halted_q || halt_i;
  assign can_take   = pend && !halted_any && !busy_o && (nmi || flags_i[IF_BIT]);
  assign start      = boundary_i && can_take;
  assign fetch_ok_o = boundary_i && !busy_o && !halted_any && !can_take;
  assign halted_o   = halted_q;

  rm_entry_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) i_fsm (
    .clk_i, .rst_ni, .start_i(start),
    .cs_i, .ip_i, .ss_i, .sp_i, .flags_i,
    .stk_addr_i(stk_addr), .vec_cs_addr_i(vec_cs_addr), .vec_ip_addr_i(vec_ip_addr),
    .mem_ready_i, .mem_rdata_i,
    .ss_cur_o(ss_cur), .sp_dec_o(sp_dec),
    .busy_o, .done_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .sp_we_o, .sp_o, .flags_we_o, .flags_o, .cs_we_o, .cs_o, .ip_we_o, .ip_o
  );

  assert_no_fetch_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !fetch_ok_o);
  assert_no_start_halted_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> !$rose(busy_o));
  assert_mask_respected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(nmi || flags_i[IF_BIT]));
  assert_start_on_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(boundary_i && pend));
  assert_no_fetch_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fetch_ok_o);
endmodule

// File: tb/test_rm_intr_entry.sv
module test_rm_intr_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise = 1'b0;
  logic [7:0]  raise_vec = '0;
  logic        halt = 1'b0;
  logic        boundary = 1'b0;
  logic        fetch_ok, busy, done, halted;
  logic [15:0] cs_m = '0, ip_m = '0, ss_m = '0, sp_m = '0, flags_m = '0;
  logic        cs_we, ip_we, sp_we, flags_we;
  logic [15:0] cs_n, ip_n, sp_n, flags_n;
  logic        mreq, mwe, mready = 1'b0;
  logic [19:0] maddr;
  logic [15:0] mwdata, mrdata;

  int unsigned n_chk = 0, n_bad = 0, cyc = 0, lat_cfg = 0, wait_cnt = 0, hold_viol = 0;
  logic        pw = 1'b0;
  logic [19:0] pa = '0;
  logic [1:0]  ev_k [16];
  logic [19:0] ev_a [16];
  logic [15:0] ev_d [16];
  int unsigned ev_n = 0;

  always #10 clk = ~clk;

  rm_intr_entry i_rm_intr_entry (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .raise_vec_i(raise_vec), .halt_i(halt),
    .boundary_i(boundary), .fetch_ok_o(fetch_ok), .busy_o(busy), .done_o(done), .halted_o(halted),
    .cs_i(cs_m), .ip_i(ip_m), .ss_i(ss_m), .sp_i(sp_m), .flags_i(flags_m),
    .cs_we_o(cs_we), .cs_o(cs_n), .ip_we_o(ip_we), .ip_o(ip_n), .sp_we_o(sp_we), .sp_o(sp_n),
    .flags_we_o(flags_we), .flags_o(flags_n),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ready_i(mready), .mem_rdata_i(mrdata)
  );

  function automatic logic [15:0] rd(input logic [19:0] a);
    return a[15:0] ^ 16'h3C5A ^ {a[19:16], 12'h000};
  endfunction
  function automatic logic [19:0] stk(input logic [15:0] s, input logic [15:0] p);
    logic [20:0] t;
    t = ({5'b0, s} << 4) + {5'b0, p};
    return t[19:0];
  endfunction

  assign mrdata = rd(maddr);

  // memory response and hold monitor
  always @(negedge clk) begin
    if (pw && !(mreq && maddr == pa)) hold_viol++;
    if (mreq) begin
      if (wait_cnt >= lat_cfg) begin mready = 1'b1; wait_cnt = 0; end
      else begin mready = 1'b0; wait_cnt++; end
    end else begin
      mready = 1'b0; wait_cnt = 0;
    end
    pw = mreq && !mready;
    pa = maddr;
  end

  // core register model and event log
  always @(posedge clk) begin
    cyc++;
    if (mreq && mready && ev_n < 16) begin
      ev_k[ev_n] = mwe ? 2'd0 : 2'd1; ev_a[ev_n] = maddr; ev_d[ev_n] = mwe ? mwdata : mrdata; ev_n++;
    end
    if (flags_we && ev_n < 16) begin
      ev_k[ev_n] = 2'd2; ev_a[ev_n] = '0; ev_d[ev_n] = flags_n; ev_n++;
    end
    if (cs_we) cs_m = cs_n;
    if (ip_we) ip_m = ip_n;
    if (sp_we) sp_m = sp_n;
    if (flags_we) flags_m = flags_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] cs, ip, ss, sp, fl, input int unsigned lat);
    @(negedge clk);
    cs_m = cs; ip_m = ip; ss_m = ss; sp_m = sp; flags_m = fl; lat_cfg = lat; ev_n = 0;
  endtask

  task automatic do_raise(input logic [7:0] v);
    @(negedge clk); raise = 1'b1; raise_vec = v;
    @(negedge clk); raise = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(seen, req, "done pulse seen", {31'b0, seen}, 32'd1);
    @(negedge clk);
    chk(!done && !busy, req, "done one cycle, busy dropped", {30'b0, done, busy}, 32'd0);
  endtask

  task automatic check_entry(input string req, input logic [7:0] v,
                             input logic [15:0] cs, ip, ss, sp, fl);
    logic [19:0] tc, ti;
    logic [1:0]  k [6];
    logic [19:0] a [6];
    logic [15:0] d [6];
    tc = {10'b0, v, 2'b10}; ti = {10'b0, v, 2'b00};
    k[0]=0; a[0]=stk(ss, sp-16'd2); d[0]=fl;
    k[1]=2; a[1]='0;               d[1]=fl & 16'hFCFF;
    k[2]=0; a[2]=stk(ss, sp-16'd4); d[2]=cs;
    k[3]=1; a[3]=tc;               d[3]=rd(tc);
    k[4]=0; a[4]=stk(ss, sp-16'd6); d[4]=ip;
    k[5]=1; a[5]=ti;               d[5]=rd(ti);
    chk(ev_n == 6, req, "event count", ev_n, 6);
    for (int i = 0; i < 6; i++)
      chk(ev_k[i] == k[i] && ev_a[i] == a[i] && ev_d[i] == d[i], req,
          $sformatf("event %0d kind/addr/data", i),
          {ev_k[i], ev_a[i][13:0], ev_d[i]}, {k[i], a[i][13:0], d[i]});
    chk(cs_m == rd(tc), req, "new CS", cs_m, rd(tc));
    chk(ip_m == rd(ti), req, "new IP", ip_m, rd(ti));
    chk(sp_m == sp - 16'd6, req, "final SP", sp_m, sp - 16'd6);
    chk(flags_m == (fl & 16'hFCFF), req, "final flags", flags_m, fl & 16'hFCFF);
  endtask

  task automatic full_entry(input string req, input logic [7:0] v, input logic [15:0] cs, ip, ss, sp, fl,
                            input int unsigned lat);
    bit s;
    setup(cs, ip, ss, sp, fl, lat);
    do_raise(v);
    boundary = 1'b1;
    wait_done(req, s);
    boundary = 1'b0;
    check_entry(req, v, cs, ip, ss, sp, fl);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !halted && !mreq, "R1", "idle after reset", {28'b0, busy, done, halted, mreq}, 0);
    chk(!cs_we && !ip_we && !sp_we && !flags_we, "R1", "no strobes", {28'b0, cs_we, ip_we, sp_we, flags_we}, 0);
    boundary = 1'b1; tick(1);
    chk(fetch_ok, "R1", "fetch_ok follows boundary high", {31'b0, fetch_ok}, 1);
    boundary = 1'b0; tick(1);
    chk(!fetch_ok, "R1", "fetch_ok follows boundary low", {31'b0, fetch_ok}, 0);
  endtask

  task automatic t_boundary();
    bit s;
    setup(16'h1234, 16'h5678, 16'h2000, 16'h0100, 16'h0202, 0);
    do_raise(8'h21);
    tick(8);
    chk(!busy && !mreq, "R5", "no entry without boundary", {30'b0, busy, mreq}, 0);
    boundary = 1'b1; #1;
    chk(!fetch_ok && !busy, "R5", "fetch held off at boundary", {30'b0, fetch_ok, busy}, 0);
    tick(1);
    chk(busy && mreq, "R5", "request one cycle after boundary", {30'b0, busy, mreq}, 32'd3);
    wait_done("R9", s);
    boundary = 1'b0;
    check_entry("R3", 8'h21, 16'h1234, 16'h5678, 16'h2000, 16'h0100, 16'h0202);
  endtask

  task automatic t_masked();
    bit s;
    setup(16'hA000, 16'h0042, 16'h0300, 16'h0800, 16'h0046, 1);
    do_raise(8'h10);
    boundary = 1'b1;
    tick(10);
    chk(!busy && fetch_ok, "R6", "masked vector waits, fetch allowed", {30'b0, busy, fetch_ok}, 1);
    flags_m = 16'h0246;
    wait_done("R6", s);
    boundary = 1'b0;
    check_entry("R6", 8'h10, 16'hA000, 16'h0042, 16'h0300, 16'h0800, 16'h0246);
  endtask

  task automatic t_busy_raise();
    bit s;
    setup(16'h0F00, 16'h0011, 16'h4000, 16'h0200, 16'h0200, 2);
    do_raise(8'h30);
    boundary = 1'b1;
    for (int i = 0; i < 20 && !busy; i++) tick(1);
    raise = 1'b1; raise_vec = 8'h31; tick(1); raise = 1'b0;
    wait_done("R11", s);
    check_entry("R11", 8'h30, 16'h0F00, 16'h0011, 16'h4000, 16'h0200, 16'h0200);
    flags_m = 16'h0200;
    tick(10);
    chk(!busy && fetch_ok, "R11", "raise during entry discarded", {30'b0, busy, fetch_ok}, 1);
    boundary = 1'b0;
  endtask

  task automatic t_halt();
    bit s;
    setup(16'h0123, 16'h4567, 16'h0700, 16'h0300, 16'h0200, 1);
    do_raise(8'h40);
    boundary = 1'b1;
    for (int i = 0; i < 20 && !busy; i++) tick(1);
    halt = 1'b1; tick(1); halt = 1'b0;
    wait_done("R8", s);
    check_entry("R8", 8'h40, 16'h0123, 16'h4567, 16'h0700, 16'h0300, 16'h0200);
    flags_m = 16'h0200;
    do_raise(8'h41);
    tick(10);
    chk(!busy && !fetch_ok && halted, "R8", "halted blocks entry and fetch",
        {29'b0, busy, fetch_ok, halted}, 1);
    boundary = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    full_entry("R2", 8'h21, 16'hF000, 16'hE05B, 16'h0030, 16'h0100, 16'h0FD7, 0);
    full_entry("R4", 8'hFF, 16'h1111, 16'h2222, 16'hFFFF, 16'h0014, 16'h0302, 3);
    full_entry("R4", 8'h08, 16'h3333, 16'h4444, 16'h1000, 16'h0000, 16'h0200, 1);
    t_boundary();
    t_masked();
    full_entry("R7", 8'h00, 16'h5555, 16'h6666, 16'h0500, 16'h0400, 16'h0102, 2);
    full_entry("R7", 8'h02, 16'h7777, 16'h8888, 16'h0500, 16'h0400, 16'h0002, 0);
    t_busy_raise();
    chk(hold_viol == 0, "R10", "request held while waiting", hold_viol, 0);
    t_halt();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule